// File: doc/BRIEF.md
# Masked Row Functional Engine (Four Rotation Lanes)

This block reduces each row of a rotated-image raster stream to one number per lane. Every input word packs four pixels, one from each of the four quarter-turn rotations of the same frame, and each pixel comes with an include bit. The block runs four independent accumulators side by side, one per lane. It finds row and column boundaries with its own counters, so the only control it needs is a valid qualifier and a start marker on the first pixel of a frame.

A build-time parameter picks the reduction. It is one of three: the plain sum of the included pixels; the sum of absolute steps between successive included pixels; or the square of the sum of the pixels' fixed-point square roots. When a row ends, the four finished values are registered together with the row number, and a one-cycle flag tells a downstream collector that they are ready. A collector can then read the lanes one after another before the next row completes.

Top module: `trace_row_functional`

## Requirements
- R1: While and after reset, `res_o`, `row_o` and `new_o` are all zero until the first row completes.
- R2: Lane i of `in_word` holds its pixel in bits [9i+7:9i] and its include bit in bit 9i+8 (1 = include). A pixel with include bit 0 contributes nothing to any reduction, and a lane with no included pixels yields 0.
- R3: Valid words that arrive before a start are ignored. A valid word with `in_start` high is always taken as column 0 of row 0, including in the middle of a frame, and anything gathered before it is dropped.
- R4: The clock edge that takes the last pixel of a row (column ROW_LEN-1) loads all four lane results into `res_o` (lane i in bits [24i+23:24i]). At the same edge `row_o` takes that row's index, and `new_o` is high for exactly the following cycle. Outside that edge `res_o` and `row_o` hold their values.
- R5: With FUNC=0, each lane's result is the sum of its included pixels in the row.
- R6: With FUNC=1, each lane's result is the sum of |p - q| over each included pixel p and the previous included pixel q of the same row. The first included pixel of a row adds nothing, and excluded pixels are skipped.
- R7: With FUNC=2, each included pixel p maps to r = floor(16*sqrt(p)), a value with 4 integer and 4 fractional bits. The lane result is the low 24 bits of (sum of r)^2.
- R8: Accumulation restarts at column 0 of every row, so rows may follow each other with no idle cycle between them and no carry-over.
- R9: Cycles with `in_valid` low do not advance the position and do not change any accumulation.
- R10: After row N_ROWS-1 is taken, the frame ends. Further valid words without a start produce no results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_start | input | 1 | Marks the first pixel of a frame (used with `in_valid`) |
| in_word | input | 36 | Four lanes of {include bit, 8-bit pixel} |
| res_o | output | 96 | Four 24-bit lane results of the last completed row |
| row_o | output | 8 | Index of the row held in `res_o` |
| new_o | output | 1 | One-cycle pulse: a new row result is ready |

## Verification
The hardest cases to reach from the ports are those where the stream and the internal position disagree. These are a start arriving partway through a row, garbage words before any start, words after the frame has ended, and idle gaps that fall right next to a row boundary. The bench uses a small configuration with 32-pixel rows and 4 rows per frame, and drives the same stream into one instance of each reduction. It sends whole frames back to back with several value and include-bit patterns. One of these, all pixels at 255, pushes the root-sum square past 24 bits so that the truncation is observable. The other cases are forced directly: a burst of unstarted words, a three-word false start followed by a real one, idle cycles inserted every few pixels, and a trailing burst after the last frame.

// File: rtl/trace_fn_pkg.sv
// Package: shared selectors and the constant helper for the row functionals.
// Assumes callers pass small non-negative values (pixel widths up to 12 bits).
package trace_fn_pkg;

    // Reduction selectors for the FUNC parameter
    localparam int FN_SUM  = 0;
    localparam int FN_DIFF = 1;
    localparam int FN_ROOT = 2;

    // floor(sqrt(v) * 2**(shift/2)), found by search; used to fill constant tables
    function automatic int unsigned isqrt_scaled(input int unsigned v, input int unsigned shift);
        int unsigned t;
        int unsigned r;
        t = v << shift;
        r = 0;
        for (int unsigned k = 0; k < (32'd1 << shift); k++) begin
            if ((k + 1) * (k + 1) <= t) r = k + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/trace_row_tracker.sv
// Module: trace_row_tracker
// Tracks column and row of the incoming raster stream. It arms on a start,
// counts valid words and disarms after the last row of the frame.
// Assumes ROW_LEN >= 2 and N_ROWS >= 2.
module trace_row_tracker #(
    parameter int ROW_LEN = 256,
    parameter int N_ROWS  = 256,
    localparam int COL_W  = $clog2(ROW_LEN),
    localparam int ROW_W  = $clog2(N_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             start,
    output logic             take,
    output logic             first,
    output logic             last,
    output logic [ROW_W-1:0] row
);

    logic             running_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col;
    logic             frame_end;

    // Current position: a start overrides the counters with column 0, row 0
    always_comb begin
        take      = valid && (start || running_q);
        col       = start ? '0 : col_q;
        row       = start ? '0 : row_q;
        first     = (col == '0);
        last      = (col == COL_W'(ROW_LEN - 1));
        frame_end = last && (row == ROW_W'(N_ROWS - 1));
    end

    // Advance the position on each taken word and stop after the final row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            col_q     <= '0;
            row_q     <= '0;
        end else if (take) begin
            if (last) begin
                col_q     <= '0;
                row_q     <= frame_end ? '0 : row + 1'b1;
                running_q <= !frame_end;
            end else begin
                col_q     <= col + 1'b1;
                row_q     <= row;
                running_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_lane_acc.sv
// Module: trace_lane_acc
// One lane's row accumulator. FUNC picks the reduction: pixel sum,
// sum of steps between included pixels, or the squared sum of Q4.4 roots.
// row_res is the finished value of the row; it is only meaningful on the
// cycle that takes the row's last pixel. Assumes ACC_W holds a full row.
module trace_lane_acc
    import trace_fn_pkg::*;
#(
    parameter int FUNC  = FN_SUM,
    parameter int PIX_W = 8,
    parameter int ACC_W = 16,
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic             msk,
    input  logic [PIX_W-1:0] pix,
    output logic [RES_W-1:0] row_res
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] contrib;
    logic [ACC_W-1:0] acc_nxt;

    // Running value; the first column of a row starts from zero
    always_comb begin
        base    = first ? '0 : acc_q;
        acc_nxt = base + contrib;
    end

    // Keep the running value between taken words
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (take) acc_q <= acc_nxt;
    end

    generate
        if (FUNC == FN_DIFF) begin : g_diff
            logic [PIX_W-1:0] prev_q;
            logic             seen_q;
            logic             seen;
            logic [PIX_W-1:0] step;

            // Step to the previous included pixel of this row
            always_comb begin
                seen    = first ? 1'b0 : seen_q;
                step    = (pix > prev_q) ? pix - prev_q : prev_q - pix;
                contrib = (msk && seen) ? ACC_W'(step) : '0;
                row_res = RES_W'(acc_nxt);
            end

            // Remember the last included pixel and whether one exists
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    seen_q <= 1'b0;
                end else if (take) begin
                    if (msk) prev_q <= pix;
                    seen_q <= seen || msk;
                end
            end
        end else if (FUNC == FN_ROOT) begin : g_root
            logic [PIX_W-1:0]   root_lut [2**PIX_W];
            logic [2*ACC_W-1:0] wide;
            logic [2*ACC_W-1:0] sq;

            for (genvar g = 0; g < 2**PIX_W; g++) begin : g_lut
                assign root_lut[g] = PIX_W'(isqrt_scaled(g, PIX_W));
            end

            // Table lookup of the root, then square the finished sum
            always_comb begin
                contrib = msk ? ACC_W'(root_lut[pix]) : '0;
                wide    = (2*ACC_W)'(acc_nxt);
                sq      = wide * wide;
                row_res = RES_W'(sq);
            end
        end else begin : g_sum
            // Plain sum of included pixels
            always_comb begin
                contrib = msk ? ACC_W'(pix) : '0;
                row_res = RES_W'(acc_nxt);
            end
        end
    endgenerate

endmodule

// File: rtl/trace_row_functional.sv
// Module: trace_row_functional (top)
// Splits each packed stream word into LANES {include, pixel} lanes, feeds
// one accumulator per lane, and registers all lane results with the row
// index at the end of each row, pulsing new_o for one cycle.
// Assumes rows of exactly ROW_LEN valid words and frames of N_ROWS rows.
module trace_row_functional
    import trace_fn_pkg::*;
#(
    parameter int FUNC    = FN_SUM,
    parameter int LANES   = 4,
    parameter int PIX_W   = 8,
    parameter int ROW_LEN = 256,
    parameter int N_ROWS  = 256,
    parameter int RES_W   = 24,
    localparam int LANE_W = PIX_W + 1,
    localparam int WORD_W = LANES * LANE_W,
    localparam int ROW_W  = $clog2(N_ROWS),
    localparam int ACC_W  = PIX_W + $clog2(ROW_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_start,
    input  logic [WORD_W-1:0]      in_word,
    output logic [LANES*RES_W-1:0] res_o,
    output logic [ROW_W-1:0]       row_o,
    output logic                   new_o
);

    logic             take;
    logic             first;
    logic             last;
    logic [ROW_W-1:0] row;
    logic [RES_W-1:0] lane_res [LANES];

    trace_row_tracker #(
        .ROW_LEN (ROW_LEN),
        .N_ROWS  (N_ROWS)
    ) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (in_valid),
        .start (in_start),
        .take  (take),
        .first (first),
        .last  (last),
        .row   (row)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        trace_lane_acc #(
            .FUNC  (FUNC),
            .PIX_W (PIX_W),
            .ACC_W (ACC_W),
            .RES_W (RES_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .first   (first),
            .msk     (in_word[l*LANE_W + PIX_W]),
            .pix     (in_word[l*LANE_W +: PIX_W]),
            .row_res (lane_res[l])
        );
    end

    // Capture all lanes and the row index when a row closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
            row_o <= '0;
            new_o <= 1'b0;
        end else begin
            new_o <= take && last;
            if (take && last) begin
                row_o <= row;
                for (int l = 0; l < LANES; l++) res_o[l*RES_W +: RES_W] <= lane_res[l];
            end
        end
    end

endmodule

// File: rtl/trace_row_functional_chk.sv
// Module: trace_row_functional_chk
// Property checker bound to every trace_row_functional instance.
// Observes only the top's ports.
module trace_row_functional_chk
    import trace_fn_pkg::*;
#(
    parameter int FUNC    = FN_SUM,
    parameter int LANES   = 4,
    parameter int PIX_W   = 8,
    parameter int ROW_LEN = 256,
    parameter int N_ROWS  = 256,
    parameter int RES_W   = 24,
    localparam int ROW_W  = $clog2(N_ROWS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [LANES*RES_W-1:0] res_o,
    input logic [ROW_W-1:0]       row_o,
    input logic                   new_o
);

    localparam longint SUM_MAX  = (64'd1 << PIX_W) * ROW_LEN - ROW_LEN;
    localparam longint DIFF_MAX = ((64'd1 << PIX_W) - 1) * (ROW_LEN - 1);

    // R4
    new_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_o |=> !new_o);

    // R4
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_o |-> $stable(res_o));

    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_o |-> $stable(row_o));

    // R9
    new_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_o |-> $past(in_valid));

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_bound
            if (FUNC == FN_SUM) begin : g_s
                // R5
                sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    new_o |-> (64'(res_o[l*RES_W +: RES_W]) <= SUM_MAX));
            end else if (FUNC == FN_DIFF) begin : g_d
                // R6
                diff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    new_o |-> (64'(res_o[l*RES_W +: RES_W]) <= DIFF_MAX));
            end
        end
    endgenerate

endmodule

bind trace_row_functional trace_row_functional_chk #(
    .FUNC    (FUNC),
    .LANES   (LANES),
    .PIX_W   (PIX_W),
    .ROW_LEN (ROW_LEN),
    .N_ROWS  (N_ROWS),
    .RES_W   (RES_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .res_o    (res_o),
    .row_o    (row_o),
    .new_o    (new_o)
);

// File: tb/trace_row_functional_tb.sv
// Bench: one instance per reduction, same stream, expected values computed here.
`timescale 1ns/1ps
module trace_row_functional_tb;

    localparam int LN = 4;
    localparam int RL = 32;
    localparam int NR = 4;
    localparam int RW = 24;
    localparam int RRW = $clog2(NR);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_start = 1'b0;
    logic [LN*9-1:0]   in_word = '0;
    logic [LN*RW-1:0]  res [3];
    logic [RRW-1:0]    rowv [3];
    logic              newv [3];

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit pend = 0;
    int pend_row = 0;
    int pix_a [LN][RL];
    bit msk_a [LN][RL];
    longint exp_r [3][LN];

    always #2 clk = ~clk;

    trace_row_functional #(.FUNC(0), .LANES(LN), .ROW_LEN(RL), .N_ROWS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_word(in_word), .res_o(res[0]), .row_o(rowv[0]), .new_o(newv[0]));
    trace_row_functional #(.FUNC(1), .LANES(LN), .ROW_LEN(RL), .N_ROWS(NR)) u_dut_diff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_word(in_word), .res_o(res[1]), .row_o(rowv[1]), .new_o(newv[1]));
    trace_row_functional #(.FUNC(2), .LANES(LN), .ROW_LEN(RL), .N_ROWS(NR)) u_dut_root (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_word(in_word), .res_o(res[2]), .row_o(rowv[2]), .new_o(newv[2]));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint root16(input int p);
        longint r = 0;
        while ((r + 1) * (r + 1) <= longint'(p) * 256) r++;
        return r;
    endfunction

    // Expected results for the row held in pix_a / msk_a
    task automatic compute_row();
        for (int l = 0; l < LN; l++) begin
            longint s = 0, d = 0, q = 0;
            int prev = 0;
            bit seen = 0;
            for (int c = 0; c < RL; c++) begin
                if (msk_a[l][c]) begin
                    s += pix_a[l][c];
                    q += root16(pix_a[l][c]);
                    if (seen) d += (pix_a[l][c] > prev) ? pix_a[l][c] - prev : prev - pix_a[l][c];
                    prev = pix_a[l][c];
                    seen = 1;
                end
            end
            exp_r[0][l] = s;
            exp_r[1][l] = d;
            exp_r[2][l] = (q * q) & 64'hFFFFFF;
        end
    endtask

    // One cycle: check outputs at the negedge, then drive the next inputs
    task automatic step(input bit v, input bit s, input logic [LN*9-1:0] w);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            chk(newv[m] == pend, "R4 new_o pulse", longint'(newv[m]), longint'(pend));
            if (pend) begin
                chk(rowv[m] == pend_row, "R4 row_o", rowv[m], pend_row);
                for (int l = 0; l < LN; l++)
                    chk(res[m][l*RW +: RW] == exp_r[m][l],
                        m == 0 ? "R5 sum (R2 R8)" : (m == 1 ? "R6 step sum (R2 R8)" : "R7 root square (R2 R8)"),
                        res[m][l*RW +: RW], exp_r[m][l]);
            end
        end
        pend = 0;
        in_valid = v;
        in_start = s;
        in_word  = w;
    endtask

    function automatic void pattern(input int f, input int r, input int c, input int l,
                                    output int p, output bit m);
        case (f)
            0: begin p = (r*37 + c*13 + l*61 + 5) & 255; m = 1; end
            1: begin p = (r*91 + c*29 + l*17 + 200) & 255; m = (l == 3) ? 0 : ((c + l + r) % 3 != 0); end
            2: begin p = 255; m = 1; end
            default: begin
                if (c % 2 == 0) begin p = 255; m = 0; end
                else begin p = (c*7 + l*30 + r) & 255; m = 1; end
            end
        endcase
    endfunction

    task automatic send_frame(input int f, input bit gaps);
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < RL; c++) begin
                logic [LN*9-1:0] w;
                for (int l = 0; l < LN; l++) begin
                    int p; bit m;
                    pattern(f, r, c, l, p, m);
                    pix_a[l][c] = p;
                    msk_a[l][c] = m;
                    w[l*9 +: 8] = p[7:0];
                    w[l*9 + 8]  = m;
                end
                if (c == RL - 1) compute_row();
                step(1, (r == 0 && c == 0), w);
                if (c == RL - 1) begin pend = 1; pend_row = r; end
                // R9: idle cycles with junk on the bus
                if (gaps && (c % 5 == 2 || c == RL - 1)) step(0, 0, {LN{9'h1FF}});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int m = 0; m < 3; m++) begin
            chk(newv[m] == 0, "R1 new_o", newv[m], 0);
            chk(rowv[m] == 0, "R1 row_o", rowv[m], 0);
            chk(res[m] == 0, "R1 res_o", res[m] != 0, 0);
        end
        rst_n = 1'b1;
        step(0, 0, '0);
        for (int m = 0; m < 3; m++) chk(res[m] == 0, "R1 res_o after reset", res[m] != 0, 0);
        // R3: unstarted words are ignored
        for (int i = 0; i < RL + 8; i++) step(1, 0, {LN{9'h1AB}});
        send_frame(0, 0);
        send_frame(1, 1);
        // R3: a false start of three words, then a real start
        step(1, 1, {LN{9'h1FF}});
        step(1, 0, {LN{9'h1FF}});
        step(1, 0, {LN{9'h1FF}});
        send_frame(2, 0);
        send_frame(3, 0);
        // R10: words after the frame end produce nothing
        for (int i = 0; i < RL + 8; i++) step(1, 0, {LN{9'h155}});
        step(0, 0, '0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule